// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store CPU Core

This block is the execution engine of a small 16-bit processor with eight general registers. It fetches one instruction at a time through a single-port memory interface that uses a request/ready handshake. It decodes the instruction and steps it through a fixed sequence of controller states. Those states cover the operate group (add, bitwise and, complement), conditional branch, PC-relative, base-relative and indirect loads and stores, load-effective-address, register jump and return, and subroutine call by offset or by register.

The core holds the three condition flags. Trap and return-from-interrupt words are not executed locally. They are passed to an external exception sequencer, which replies with the next PC. A reserved opcode stops the core and raises a sticky error flag that only reset clears.

Top module: `cpu16_core`

## Requirements
- R1: After reset the first fetch is at address 0x3000, `status` reads 0x8002 (bit 15 user mode = 1, priority bits [10:8] = 0, flags [2:0] = Z), `illegal` is low, and all eight registers read zero.
- R2: The flags are one-hot (N = 3'b100, Z = 3'b010, P = 3'b001) and are set from the sign of the 16-bit result read as two's complement. Add, and, complement and all three loads update them. Load-effective-address (opcode 4'b1110) leaves them unchanged.
- R3: Opcodes 4'b0001 (add) and 4'b0101 (and) take bit [5] as the operand select: 1 means the sign-extended bits [4:0], 0 means the register in [2:0]. Opcode 4'b1001 complements the register in [8:6]. In every case the destination is [11:9].
- R4: Opcode 4'b0000 with mask [11:9] branches when the mask AND the flags is nonzero. The target is the incremented PC plus the sign-extended bits [8:0]. Negative offsets are allowed.
- R5: Opcodes 4'b0010/4'b0011 load and store at the incremented PC plus sext([8:0]). Opcodes 4'b0110/4'b0111 use the base register [8:6] plus sext([5:0]). Opcode 4'b1110 writes the incremented PC plus sext([8:0]) into the register. All sums wrap modulo 2^16.
- R6: Opcodes 4'b1010/4'b1011 first read a pointer at the incremented PC plus sext([8:0]). They then load from, or store to, the address held in that pointer.
- R7: Opcode 4'b0100 writes the incremented PC into R7 and then jumps. The target is the PC plus sext([10:0]) when bit [11] is 1, otherwise the base register [8:6]. Opcode 4'b1100 jumps to the base register [8:6].
- R8: A memory request holds its address, write enable and write data steady until ready is seen. Each accepted handshake is exactly one access, and the accesses come in program order.
- R9: Opcodes 4'b1111 and 4'b1000 raise `exc_req` with the instruction word and the incremented PC, both held steady until `exc_done`. Execution then resumes at `exc_target`. Memory and exception requests never overlap.
- R10: Opcode 4'b1101 sets `illegal`, which stays set. After that the core issues no memory or exception request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes on this edge |
| exc_req | output | 1 | Trap/return word handed to the exception sequencer |
| exc_word | output | 16 | The instruction word being handed over |
| exc_ret_pc | output | 16 | Incremented PC of that instruction |
| exc_done | input | 1 | Sequencer finished |
| exc_target | input | 16 | PC at which to resume |
| status | output | 16 | Status word: mode, priority, flags |
| illegal | output | 1 | Sticky reserved-opcode error |

## Verification
One program exercises every opcode class, and each memory transaction is compared with a trace from an instruction-level model. Register values become visible through stores, and the next fetch address shows whether a branch or jump went the right way. A branch taken on the Z flag, a branch not taken on a P mask, and a branch taken on N just after a load-effective-address together show that the flags are one-hot and that the address instruction leaves them alone. A loop with a negative offset checks backward branch arithmetic. The memory reply latency cycles through 0, 1 and 2 wait cycles, so each access class is tried with both immediate and delayed ready. A trap followed by a return-from-interrupt checks the handshake with the sequencer and the resume PC.

// File: rtl/cpu16_pkg.sv
// Package: shared encodings for the multicycle 16-bit core.
// Assumes a fixed 16-bit instruction word with a 4-bit opcode in [15:12].
package cpu16_pkg;
    localparam int WORD_W  = 16;
    localparam int REG_AW  = 3;
    localparam int OPC_W   = 4;
    localparam int FLAG_W  = 3;

    localparam logic [FLAG_W-1:0] FLAG_N = 3'b100;
    localparam logic [FLAG_W-1:0] FLAG_Z = 3'b010;
    localparam logic [FLAG_W-1:0] FLAG_P = 3'b001;

    typedef enum logic [OPC_W-1:0] {
        OP_BR   = 4'h0, OP_ADD  = 4'h1, OP_LD   = 4'h2, OP_ST   = 4'h3,
        OP_JSR  = 4'h4, OP_AND  = 4'h5, OP_LDR  = 4'h6, OP_STR  = 4'h7,
        OP_RTI  = 4'h8, OP_NOT  = 4'h9, OP_LDI  = 4'hA, OP_STI  = 4'hB,
        OP_JMP  = 4'hC, OP_RSV  = 4'hD, OP_LEA  = 4'hE, OP_TRAP = 4'hF
    } opcode_t;

    typedef enum logic [2:0] {
        ST_FETCH, ST_DECODE, ST_EXEC, ST_MEM1, ST_MEM2, ST_WB, ST_EXC, ST_STOP
    } ctrl_state_t;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_AND, ALU_NOT
    } alu_op_t;
endpackage

// File: rtl/cpu16_regfile.sv
// Module: general register file, two combinational read ports, one write port.
// Assumes a single writer per cycle; every register clears on reset.
module cpu16_regfile #(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 16,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [AW-1:0]     rd_sel_a,
    input  logic [AW-1:0]     rd_sel_b,
    output logic [DATA_W-1:0] rd_val_a,
    output logic [DATA_W-1:0] rd_val_b
);
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    // Register storage: clear on reset, single write per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else if (wr_en) begin
            regs_q[wr_sel] <= wr_val;
        end
    end

    // Read ports.
    always_comb begin
        rd_val_a = regs_q[rd_sel_a];
        rd_val_b = regs_q[rd_sel_b];
    end
endmodule

// File: rtl/cpu16_alu.sv
// Module: operate-group arithmetic (add, and, complement).
// Assumes operands are already selected and sign-extended by the caller.
module cpu16_alu
    import cpu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_t           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res
);
    // Result select.
    always_comb begin
        unique case (op)
            ALU_ADD: res = opa + opb;
            ALU_AND: res = opa & opb;
            default: res = ~opa;
        endcase
    end
endmodule

// File: rtl/cpu16_flags.sv
// Module: one-hot flag generation from a result, plus the branch mask test.
// Assumes results are two's-complement values of DATA_W bits.
module cpu16_flags
    import cpu16_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] value,
    input  logic [FLAG_W-1:0] cur_flags,
    input  logic [FLAG_W-1:0] br_mask,
    output logic [FLAG_W-1:0] new_flags,
    output logic              br_taken
);
    // Sign classification of the result.
    always_comb begin
        if (value[DATA_W-1])  new_flags = FLAG_N;
        else if (value == '0) new_flags = FLAG_Z;
        else                  new_flags = FLAG_P;
    end

    // Branch condition: any selected flag set.
    assign br_taken = |(br_mask & cur_flags);
endmodule

// File: rtl/cpu16_core.sv
// Module: multicycle controller and datapath of the 16-bit core.
// Assumes mem_rdata is valid in the cycle mem_ready is high, and that the
// exception sequencer supplies the resume PC together with exc_done.
module cpu16_core
    import cpu16_pkg::*;
#(
    parameter int          NUM_REGS = 8,
    parameter logic [15:0] RESET_PC = 16'h3000,
    localparam int         DW       = WORD_W,
    localparam logic [REG_AW-1:0] LINK_REG = REG_AW'(NUM_REGS - 1),
    localparam logic [DW-FLAG_W-1:0] STATUS_HI = 13'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          mem_req,
    output logic          mem_we,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic          exc_req,
    output logic [DW-1:0] exc_word,
    output logic [DW-1:0] exc_ret_pc,
    input  logic          exc_done,
    input  logic [DW-1:0] exc_target,
    output logic [DW-1:0] status,
    output logic          illegal
);
    ctrl_state_t        state_q;
    logic [DW-1:0]      pc_q, ir_q, a_q, b_q, addr_q, wb_q;
    logic               wb_flags_q;
    logic [FLAG_W-1:0]  flags_q;
    logic               illegal_q;

    opcode_t            op;
    logic               is_store;
    logic [DW-1:0]      pc_off9, pc_off11, base_off6, alu_b, alu_res;
    alu_op_t            alu_op;
    logic [FLAG_W-1:0]  flags_next;
    logic               br_taken;
    logic               rf_we;
    logic [REG_AW-1:0]  rf_wsel, rf_sel_b;
    logic [DW-1:0]      rf_wval, rf_rd_a, rf_rd_b;

    function automatic logic [DW-1:0] sext(input logic [DW-1:0] v, input int unsigned n);
        logic [DW-1:0] hi;
        hi = {DW{1'b1}} << n;
        return v[n-1] ? (v | hi) : (v & ~hi);
    endfunction

    // Instruction field decode and address arithmetic.
    always_comb begin
        op        = opcode_t'(ir_q[15:12]);
        is_store  = (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
        pc_off9   = pc_q + sext(ir_q, 9);
        pc_off11  = pc_q + sext(ir_q, 11);
        base_off6 = a_q + sext(ir_q, 6);
        alu_b     = ir_q[5] ? sext(ir_q, 5) : b_q;
        alu_op    = (op == OP_ADD) ? ALU_ADD : (op == OP_AND) ? ALU_AND : ALU_NOT;
        rf_sel_b  = is_store ? ir_q[11:9] : ir_q[2:0];
    end

    // Register write port: link write on call, otherwise writeback.
    always_comb begin
        rf_we   = (state_q == ST_WB) || (state_q == ST_EXEC && op == OP_JSR);
        rf_wsel = (state_q == ST_EXEC) ? LINK_REG : ir_q[11:9];
        rf_wval = (state_q == ST_EXEC) ? pc_q : wb_q;
    end

    cpu16_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(rf_we), .wr_sel(rf_wsel), .wr_val(rf_wval),
        .rd_sel_a(ir_q[8:6]), .rd_sel_b(rf_sel_b), .rd_val_a(rf_rd_a), .rd_val_b(rf_rd_b)
    );

    cpu16_alu #(.DATA_W(DW)) i_alu (
        .op(alu_op), .opa(a_q), .opb(alu_b), .res(alu_res)
    );

    cpu16_flags #(.DATA_W(DW)) i_flags (
        .value(wb_q), .cur_flags(flags_q), .br_mask(ir_q[11:9]),
        .new_flags(flags_next), .br_taken(br_taken)
    );

    // Controller sequencing and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_FETCH;
            pc_q       <= RESET_PC;
            ir_q       <= '0;
            a_q        <= '0;
            b_q        <= '0;
            addr_q     <= '0;
            wb_q       <= '0;
            wb_flags_q <= 1'b0;
            flags_q    <= FLAG_Z;
            illegal_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: if (mem_ready) begin
                    ir_q    <= mem_rdata;
                    pc_q    <= pc_q + 16'd1;
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    a_q <= rf_rd_a;
                    b_q <= rf_rd_b;
                    if (op == OP_RSV) begin
                        illegal_q <= 1'b1;
                        state_q   <= ST_STOP;
                    end else if (op == OP_TRAP || op == OP_RTI) begin
                        state_q <= ST_EXC;
                    end else begin
                        state_q <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH;
                    unique case (op)
                        OP_ADD, OP_AND, OP_NOT: begin
                            wb_q <= alu_res; wb_flags_q <= 1'b1; state_q <= ST_WB;
                        end
                        OP_LEA: begin
                            wb_q <= pc_off9; wb_flags_q <= 1'b0; state_q <= ST_WB;
                        end
                        OP_BR:  if (br_taken) pc_q <= pc_off9;
                        OP_JMP: pc_q <= a_q;
                        OP_JSR: pc_q <= ir_q[11] ? pc_off11 : a_q;
                        OP_LD, OP_ST: begin
                            addr_q <= pc_off9; state_q <= ST_MEM2;
                        end
                        OP_LDR, OP_STR: begin
                            addr_q <= base_off6; state_q <= ST_MEM2;
                        end
                        OP_LDI, OP_STI: begin
                            addr_q <= pc_off9; state_q <= ST_MEM1;
                        end
                        default: ;
                    endcase
                end
                ST_MEM1: if (mem_ready) begin
                    addr_q  <= mem_rdata;
                    state_q <= ST_MEM2;
                end
                ST_MEM2: if (mem_ready) begin
                    if (is_store) begin
                        state_q <= ST_FETCH;
                    end else begin
                        wb_q       <= mem_rdata;
                        wb_flags_q <= 1'b1;
                        state_q    <= ST_WB;
                    end
                end
                ST_WB: begin
                    if (wb_flags_q) flags_q <= flags_next;
                    state_q <= ST_FETCH;
                end
                ST_EXC: if (exc_done) begin
                    pc_q    <= exc_target;
                    state_q <= ST_FETCH;
                end
                default: state_q <= ST_STOP;
            endcase
        end
    end

    // External interface drive.
    always_comb begin
        mem_req    = (state_q == ST_FETCH) || (state_q == ST_MEM1) || (state_q == ST_MEM2);
        mem_we     = (state_q == ST_MEM2) && is_store;
        mem_addr   = (state_q == ST_FETCH) ? pc_q : addr_q;
        mem_wdata  = b_q;
        exc_req    = (state_q == ST_EXC);
        exc_word   = ir_q;
        exc_ret_pc = pc_q;
        status     = {STATUS_HI, flags_q};
        illegal    = illegal_q;
    end
endmodule

// File: rtl/cpu16_core_chk.sv
// Module: protocol and state checker bound to the core.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module cpu16_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        mem_ready,
    input logic        exc_req,
    input logic [15:0] exc_word,
    input logic [15:0] exc_ret_pc,
    input logic        exc_done,
    input logic [15:0] status,
    input logic        illegal
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    assert_exc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_req && !exc_done |=> exc_req && $stable(exc_word) && $stable(exc_ret_pc));

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && exc_req));

    assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(status[2:0]) == 1);

    assert_illegal_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> illegal);

    assert_quiet_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !mem_req && !exc_req);
endmodule

bind cpu16_core cpu16_core_chk i_chk (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .exc_req(exc_req), .exc_word(exc_word),
    .exc_ret_pc(exc_ret_pc), .exc_done(exc_done), .status(status), .illegal(illegal)
);

// File: tb/test_cpu16_core.sv
module test_cpu16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, exc_req, illegal;
    logic [15:0] mem_addr, mem_wdata, exc_word, exc_ret_pc, status;
    logic [15:0] mem_rdata = '0, exc_target = '0;
    logic        mem_ready = 1'b0, exc_done = 1'b0;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    cpu16_core i_cpu16_core (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .exc_req(exc_req), .exc_word(exc_word), .exc_ret_pc(exc_ret_pc),
        .exc_done(exc_done), .exc_target(exc_target), .status(status), .illegal(illegal)
    );

    logic [15:0] mem [4096];
    logic [15:0] mm  [4096];

    bit          q_we[$];
    logic [15:0] q_addr[$];
    logic [15:0] q_data[$];
    string       q_tag[$];
    logic [15:0] qe_word[$];
    logic [15:0] qe_pc[$];
    logic [2:0]  exp_flags;

    task automatic check(input bit ok, input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic place(input int a, input logic [15:0] w);
        mem[a[11:0]] = w;
        mm[a[11:0]]  = w;
    endtask

    function automatic logic [15:0] w9(input int op, input int r, input int off);
        logic [31:0] o = off;
        return {op[3:0], r[2:0], o[8:0]};
    endfunction
    function automatic logic [15:0] w6(input int op, input int r, input int b, input int off);
        logic [31:0] o = off;
        return {op[3:0], r[2:0], b[2:0], o[5:0]};
    endfunction
    function automatic logic [15:0] wi(input int op, input int d, input int s, input int imm);
        logic [31:0] o = imm;
        return {op[3:0], d[2:0], s[2:0], 1'b1, o[4:0]};
    endfunction
    function automatic logic [15:0] wr(input int op, input int d, input int s1, input int s2);
        return {op[3:0], d[2:0], s1[2:0], 3'b000, s2[2:0]};
    endfunction
    function automatic logic [15:0] sx(input logic [15:0] v, input int n);
        int k = v & ((1 << n) - 1);
        if (k >= (1 << (n - 1))) k = k - (1 << n);
        return 16'(k);
    endfunction
    function automatic logic [2:0] sign_flags(input logic [15:0] v);
        if ($signed(v) < 0) return 3'b100;
        if (v == 0) return 3'b010;
        return 3'b001;
    endfunction

    task automatic push_t(input bit we, input logic [15:0] a, input logic [15:0] d, input string t);
        q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
    endtask

    // Instruction-level model producing the expected access trace.
    task automatic run_model();
        logic [15:0] r [8];
        logic [15:0] pc = 16'h3000, w, ea, p, v2, res;
        logic [15:0] stk[$];
        logic [2:0]  fl = 3'b010;
        string       tag = "R1";
        bit          stop = 0;
        for (int i = 0; i < 8; i++) r[i] = 0;
        for (int n = 0; n < 500 && !stop; n++) begin
            push_t(0, pc, 0, tag);
            w  = mm[pc[11:0]];
            pc = pc + 1;
            case (w[15:12])
                4'h0: begin if ((w[11:9] & fl) != 0) pc = pc + sx(w, 9); tag = "R4"; end
                4'h1, 4'h5: begin
                    v2  = w[5] ? sx(w, 5) : r[w[2:0]];
                    res = (w[15:12] == 4'h1) ? r[w[8:6]] + v2 : r[w[8:6]] & v2;
                    r[w[11:9]] = res; fl = sign_flags(res); tag = "R3";
                end
                4'h9: begin res = ~r[w[8:6]]; r[w[11:9]] = res; fl = sign_flags(res); tag = "R3"; end
                4'h2: begin ea = pc + sx(w, 9); push_t(0, ea, 0, "R5"); r[w[11:9]] = mm[ea[11:0]];
                            fl = sign_flags(mm[ea[11:0]]); tag = "R2"; end
                4'h3: begin ea = pc + sx(w, 9); push_t(1, ea, r[w[11:9]], "R5"); mm[ea[11:0]] = r[w[11:9]]; tag = "R5"; end
                4'h6: begin ea = r[w[8:6]] + sx(w, 6); push_t(0, ea, 0, "R5"); r[w[11:9]] = mm[ea[11:0]];
                            fl = sign_flags(mm[ea[11:0]]); tag = "R5"; end
                4'h7: begin ea = r[w[8:6]] + sx(w, 6); push_t(1, ea, r[w[11:9]], "R5"); mm[ea[11:0]] = r[w[11:9]]; tag = "R5"; end
                4'hA: begin p = pc + sx(w, 9); push_t(0, p, 0, "R6"); ea = mm[p[11:0]]; push_t(0, ea, 0, "R6");
                            r[w[11:9]] = mm[ea[11:0]]; fl = sign_flags(mm[ea[11:0]]); tag = "R6"; end
                4'hB: begin p = pc + sx(w, 9); push_t(0, p, 0, "R6"); ea = mm[p[11:0]];
                            push_t(1, ea, r[w[11:9]], "R6"); mm[ea[11:0]] = r[w[11:9]]; tag = "R6"; end
                4'hE: begin r[w[11:9]] = pc + sx(w, 9); tag = "R5"; end
                4'hC: begin pc = r[w[8:6]]; tag = "R7"; end
                4'h4: begin ea = w[11] ? pc + sx(w, 11) : r[w[8:6]]; r[7] = pc; pc = ea; tag = "R7"; end
                4'hF: begin qe_word.push_back(w); qe_pc.push_back(pc); stk.push_back(pc);
                            pc = 16'h3200 + {8'h00, w[7:0]}; tag = "R9"; end
                4'h8: begin qe_word.push_back(w); qe_pc.push_back(pc); pc = stk.pop_back(); tag = "R9"; end
                default: stop = 1;
            endcase
        end
        exp_flags = fl;
    endtask

    task automatic load_program();
        for (int i = 0; i < 4096; i++) begin mem[i] = 16'h0; mm[i] = 16'h0; end
        place('h3000, wi(5,0,0,0));    place('h3001, wi(1,1,0,-3));   place('h3002, wi(1,2,1,5));
        place('h3003, wr(1,3,1,2));    place('h3004, {4'h9,3'd4,3'd3,6'h3F});
        place('h3005, w9(0,2,1));      place('h3006, wi(1,0,0,1));    place('h3007, w9(0,1,1));
        place('h3008, w9(3,3,'h37));   place('h3009, w9(2,5,'h37));   place('h300A, w9(14,7,'h35));
        place('h300B, w9(0,4,1));      place('h300C, wi(1,0,0,1));    place('h300D, w6(6,6,7,1));
        place('h300E, w6(7,2,7,2));    place('h300F, w9(10,0,'h33));  place('h3010, w9(11,1,'h34));
        place('h3011, {5'b01001, 11'h00E}); place('h3012, w9(14,6,'h15));
        place('h3013, {4'h4,3'd0,3'd6,6'h0}); place('h3014, wi(5,5,0,15)); place('h3015, wr(5,4,0,3));
        place('h3016, w9(3,5,'h31));   place('h3017, w9(3,4,'h31));   place('h3018, w9(3,0,'h31));
        place('h3019, 16'hF021);       place('h301A, w9(3,1,'h30));   place('h301B, wi(1,2,2,-1));
        place('h301C, w9(0,1,-2));     place('h301D, wi(1,3,1,0));    place('h301E, 16'hD000);
        place('h3020, wi(1,0,0,-1));   place('h3021, {4'hC,3'd0,3'd7,6'h0});
        place('h3028, w9(3,7,'h1E));   place('h3029, {4'hC,3'd0,3'd7,6'h0});
        place('h3221, wi(1,1,1,1));    place('h3222, 16'h8000);
        place('h3041, 16'h8000);       place('h3043, 16'h3044);
        place('h3044, 16'h1234);       place('h3045, 16'h3046);
    endtask

    // Memory and exception-sequencer responder, evaluated on every falling edge.
    task automatic serve();
        int cnt = 0, tnum = 0, ecnt = 0;
        bit cap_we = 0;
        logic [15:0] cap_a = 0, cap_d = 0, e;
        logic [15:0] estk[$];
        string t;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                if (q_we.size() == 0) begin
                    check(0, "R8", cap_a, 16'hxxxx);
                end else begin
                    t = q_tag.pop_front();
                    check(q_we[0] == cap_we && q_addr[0] == cap_a, t, cap_a, q_addr[0]);
                    if (q_we[0]) check(cap_d == q_data[0], t, cap_d, q_data[0]);
                    void'(q_we.pop_front()); void'(q_addr.pop_front()); void'(q_data.pop_front());
                end
                if (cap_we) mem[cap_a[11:0]] = cap_d;
                mem_ready = 0; cnt = 0; tnum++;
            end
            if (rst_n && mem_req) begin
                if (cnt >= tnum % 3) begin
                    cap_we = mem_we; cap_a = mem_addr; cap_d = mem_wdata;
                    mem_rdata = mem[mem_addr[11:0]]; mem_ready = 1;
                end else cnt++;
            end
            if (exc_done) begin
                exc_done = 0; ecnt = 0;
            end else if (rst_n && exc_req) begin
                if (ecnt == 0) begin
                    e = (qe_word.size() > 0) ? qe_word.pop_front() : 16'hxxxx;
                    check(exc_word === e, "R9", exc_word, e);
                    e = (qe_pc.size() > 0) ? qe_pc.pop_front() : 16'hxxxx;
                    check(exc_ret_pc === e, "R9", exc_ret_pc, e);
                end
                ecnt++;
                if (ecnt == 3) begin
                    if (exc_word[15:12] == 4'hF) begin
                        estk.push_back(exc_ret_pc);
                        exc_target = 16'h3200 + {8'h00, exc_word[7:0]};
                    end else exc_target = estk.pop_back();
                    exc_done = 1;
                end
            end
        end
    endtask

    initial begin
        int cyc = 0;
        bit quiet = 1;
        load_program();
        run_model();
        fork serve(); join_none
        repeat (3) @(negedge clk);
        check(status == 16'h8002, "R1", status, 16'h8002);
        check(illegal == 1'b0, "R1", {15'b0, illegal}, 16'h0);
        rst_n = 1'b1;
        while (!illegal && cyc < 5000) begin @(negedge clk); cyc++; end
        check(cyc < 5000, "R10 watchdog", 16'(cyc), 16'd5000);
        check(illegal == 1'b1, "R10", {15'b0, illegal}, 16'h1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (mem_req || exc_req || !illegal) quiet = 0;
        end
        check(quiet, "R10", {15'b0, quiet}, 16'h1);
        check(q_we.size() == 0, "R8", 16'(q_we.size()), 16'h0);
        check(qe_word.size() == 0, "R9", 16'(qe_word.size()), 16'h0);
        check(status == {13'h1000, exp_flags}, "R2", status, {13'h1000, exp_flags});
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule